// File: doc/BRIEF.md
# Write-Through Data Cache Controller

This block sits between the memory stage of a pipelined processor and a word-wide main memory. It accepts byte-addressed loads and stores and keeps a direct-mapped copy of sixteen 32-bit words, held as four lines of four words each. A load that finds its line present returns data in the same cycle with no stall. A load that misses, and every store, raises a stall for a fixed penalty of five cycles while main memory is accessed.

A load miss fetches the whole four-word line during the penalty window, then records the tag and sets the valid bit. The requested word is on the read-data output in the cycle the stall drops. Stores always go to main memory. A store that hits also updates the cached word. A store that misses leaves the cache unchanged. The pipeline is expected to hold its request steady while the stall is high. In the first cycle after the stall drops (the release cycle) the held request is treated as completed and is not issued again.

Top module: `wthru_dcache`

## Requirements
- R1: After reset the stall output and both memory strobes are low, and every line is invalid, so the first load to any address misses.
- R2: Address bits [1:0] select a byte and are ignored. Bits [3:2] select the word within a line, bits [5:4] select the line, and bits [31:6] form the tag. The memory address is always word aligned, with bits [1:0] zero.
- R3: A load that hits returns the cached word combinationally and never raises the stall.
- R4: A load miss or any store raises the stall in the cycle after the request is seen. The stall then stays high for exactly five consecutive cycles.
- R5: On a load miss, the memory read strobe is high for the first four stall cycles. The memory addresses in those cycles are words 0, 1, 2, 3 of the line, in that order. After the miss, every word of the line hits.
- R6: After a load miss, the read-data output carries the requested word in the cycle the stall falls.
- R7: Each store drives the memory write strobe for exactly one cycle, the first stall cycle, with the word-aligned store address and the store data.
- R8: A store that hits updates the cached word, so a later load of that address hits and returns the new value.
- R9: A store that misses does not allocate a line. A later load of that address misses, and lines held at other indices are unaffected.
- R10: Two addresses with the same line index and different tags evict each other.
- R11: A request still held during the release cycle is not re-issued: it causes no new stall and no second memory write.
- R12: The memory read and write strobes are never high together, and neither is high outside a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd | input | 1 | Load request |
| cpu_wr | input | 1 | Store request (wins if both are high) |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data |
| cpu_stall | output | 1 | Registered stall to the pipeline |
| mem_rd | output | 1 | Main memory read strobe |
| mem_wr | output | 1 | Main memory write strobe |
| mem_addr | output | 32 | Word-aligned main memory byte address |
| mem_wdata | output | 32 | Main memory write data |
| mem_rdata | input | 32 | Main memory read data, valid in the cycle the read strobe is high |

## Verification
A store hit writes the cached word and drives the memory write in the same first stall cycle. The bench provokes this by loading a line and then storing into it. It judges the result in two ways: the write captured on the memory side must carry the right address and data, and the following load must hit with the new value and no stall. The release cycle can also meet a request that is still held. The bench keeps every request asserted through the release edge, then checks that the stall stays low and that the memory write count has not moved.

// File: rtl/dc_pkg.sv
// Package: shared geometry and controller state for the write-through data cache.
// Assumes a 32-bit byte address and 32-bit words.
package dc_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    // Controller phases: idle, load-miss refill, store write-through, release
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_REFILL  = 2'd1,
        PH_STORE   = 2'd2,
        PH_RELEASE = 2'd3
    } dc_phase_e;
endpackage

// File: rtl/dc_addr_split.sv
// Module: splits a byte address into tag, line index and word offset.
// Assumes the byte-in-word bits are below the word offset and are unused.
module dc_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int WORD_W = 2,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - OFF_W - WORD_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    logic unused_byte_bits;

    // Field extraction
    always_comb begin
        word = addr[OFF_W +: WORD_W];
        idx  = addr[OFF_W+WORD_W +: IDX_W];
        tag  = addr[ADDR_W-1 -: TAG_W];
        unused_byte_bits = ^addr[OFF_W-1:0];
    end
endmodule

// File: rtl/dc_lines.sv
// Module: tag, valid and data storage for a direct-mapped cache.
// One lookup port (combinational) and one word write port; tag/valid
// are written separately when a refill completes. Only valid bits reset.
module dc_lines #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 26,
    parameter int IDX_W  = 2,
    parameter int WORD_W = 2,
    localparam int LINES = 1 << IDX_W,
    localparam int WORDS = 1 << WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [WORD_W-1:0] lk_word,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              w_en,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [WORD_W-1:0] w_word,
    input  logic [DATA_W-1:0] w_data,
    input  logic              t_en,
    input  logic [IDX_W-1:0]  t_idx,
    input  logic [TAG_W-1:0]  t_tag
);
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES][WORDS];

    for (genvar b = 0; b < LINES; b++) begin : g_line
        // Valid bit of this line: cleared by reset, set when its tag is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q[b] <= 1'b0;
            else if (t_en && t_idx == IDX_W'(b))
                valid_q[b] <= 1'b1;
        end

        // Tag of this line
        always_ff @(posedge clk) begin
            if (t_en && t_idx == IDX_W'(b))
                tag_q[b] <= t_tag;
        end

        for (genvar w = 0; w < WORDS; w++) begin : g_word
            // One data word of this line
            always_ff @(posedge clk) begin
                if (w_en && w_idx == IDX_W'(b) && w_word == WORD_W'(w))
                    data_q[b][w] <= w_data;
            end
        end
    end

    // Lookup: hit compare and word select
    always_comb begin
        lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_data = data_q[lk_idx][lk_word];
    end
endmodule

// File: rtl/dc_ctrl.sv
// Module: penalty sequencer. Accepts a load miss or any store while idle,
// latches it, holds a registered stall for PENALTY cycles, drives the
// memory side (refill words in order, or one write), then spends one
// release cycle in which the held request is not accepted again.
// Assumes PENALTY >= number of words per line.
module dc_ctrl
    import dc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 26,
    parameter int IDX_W   = 2,
    parameter int WORD_W  = 2,
    parameter int OFF_W   = 2,
    parameter int PENALTY = 5,
    localparam int WORDS  = 1 << WORD_W,
    localparam int CNT_W  = $clog2(PENALTY),
    localparam int ADDR_W = TAG_W + IDX_W + WORD_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              hit,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [WORD_W-1:0] in_word,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              stall,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fill_en,
    output logic              fill_last,
    output logic              upd_en,
    output logic [IDX_W-1:0]  line_idx,
    output logic [WORD_W-1:0] line_word,
    output logic [TAG_W-1:0]  line_tag
);
    dc_phase_e         phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              stall_q;
    logic              hit_q;
    logic [TAG_W-1:0]  tag_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] word_q;
    logic [DATA_W-1:0] wdata_q;
    logic              start;
    logic              last_cyc;
    logic              busy;

    // Accept decision and end-of-penalty detect
    always_comb begin
        start    = (phase_q == PH_IDLE) && (wr_req || (rd_req && !hit));
        busy     = (phase_q == PH_REFILL) || (phase_q == PH_STORE);
        last_cyc = busy && (cnt_q == CNT_W'(PENALTY - 1));
    end

    // Phase and penalty counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= wr_req ? PH_STORE : PH_REFILL;
                    cnt_q   <= '0;
                end
                PH_REFILL, PH_STORE: if (last_cyc)
                    phase_q <= PH_RELEASE;
                else
                    cnt_q <= cnt_q + 1'b1;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Registered stall: set on accept, cleared after the last penalty cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            stall_q <= 1'b0;
        else if (start)
            stall_q <= 1'b1;
        else if (last_cyc)
            stall_q <= 1'b0;
    end

    // Request latch, captured on accept
    always_ff @(posedge clk) begin
        if (start) begin
            hit_q   <= hit;
            tag_q   <= in_tag;
            idx_q   <= in_idx;
            word_q  <= in_word;
            wdata_q <= in_wdata;
        end
    end

    // Memory side and line write controls
    always_comb begin
        stall     = stall_q;
        mem_rd    = (phase_q == PH_REFILL) && (cnt_q < CNT_W'(WORDS));
        mem_wr    = (phase_q == PH_STORE) && (cnt_q == '0);
        fill_en   = mem_rd;
        fill_last = mem_rd && (cnt_q == CNT_W'(WORDS - 1));
        upd_en    = mem_wr && hit_q;
        line_idx  = idx_q;
        line_tag  = tag_q;
        line_word = (phase_q == PH_REFILL) ? cnt_q[WORD_W-1:0] : word_q;
        mem_addr  = {tag_q, idx_q, line_word, {OFF_W{1'b0}}};
        mem_wdata = wdata_q;
    end
endmodule

// File: rtl/wthru_dcache.sv
// Module: top of the write-through, no-allocate, direct-mapped data cache.
// Assumes the pipeline holds its request stable while cpu_stall is high,
// and main memory returns read data in the cycle mem_rd is high.
module wthru_dcache
    import dc_pkg::*;
#(
    parameter int IDX_W   = 2,
    parameter int WORD_W  = 2,
    parameter int PENALTY = 5,
    localparam int OFF_W  = $clog2(DATA_W / 8),
    localparam int TAG_W  = ADDR_W - OFF_W - WORD_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WORD_W-1:0] a_word;
    logic              hit;
    logic              fill_en, fill_last, upd_en;
    logic [IDX_W-1:0]  l_idx;
    logic [WORD_W-1:0] l_word;
    logic [TAG_W-1:0]  l_tag;
    logic [DATA_W-1:0] l_wdata;

    dc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) split_i (
        .addr(cpu_addr), .tag(a_tag), .idx(a_idx), .word(a_word)
    );

    dc_ctrl #(.DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .WORD_W(WORD_W),
              .OFF_W(OFF_W), .PENALTY(PENALTY)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .rd_req(cpu_rd), .wr_req(cpu_wr), .hit(hit),
        .in_tag(a_tag), .in_idx(a_idx), .in_word(a_word), .in_wdata(cpu_wdata),
        .stall(cpu_stall), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .fill_en(fill_en), .fill_last(fill_last), .upd_en(upd_en),
        .line_idx(l_idx), .line_word(l_word), .line_tag(l_tag)
    );

    // Word written into the line: refill data or the store data
    always_comb l_wdata = fill_en ? mem_rdata : mem_wdata;

    dc_lines #(.DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .WORD_W(WORD_W)) lines_i (
        .clk(clk), .rst_n(rst_n),
        .lk_tag(a_tag), .lk_idx(a_idx), .lk_word(a_word),
        .lk_hit(hit), .lk_data(cpu_rdata),
        .w_en(fill_en || upd_en), .w_idx(l_idx), .w_word(l_word), .w_data(l_wdata),
        .t_en(fill_last), .t_idx(l_idx), .t_tag(l_tag)
    );
endmodule

// File: rtl/wthru_dcache_chk.sv
// Module: protocol checker for wthru_dcache, attached by bind.
// Counts consecutive stall cycles so the penalty window needs no long $past.
module wthru_dcache_chk #(
    parameter int PENALTY = 5
) (
    input logic clk,
    input logic rst_n,
    input logic cpu_rd,
    input logic cpu_wr,
    input logic cpu_stall,
    input logic mem_rd,
    input logic mem_wr
) ;
    logic [7:0] run_q;

    // Length of the current stall run
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (cpu_stall)
            run_q <= run_q + 1'b1;
        else
            run_q <= '0;
    end

    assert_stall_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> run_q == 8'(PENALTY));

    assert_stall_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> run_q < 8'(PENALTY));

    assert_stall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(cpu_rd || cpu_wr));

    assert_wr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_strobe_in_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> cpu_stall);
endmodule

bind wthru_dcache wthru_dcache_chk #(.PENALTY(PENALTY)) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_stall(cpu_stall), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/wthru_dcache_tb_top.sv
// Bench: scoreboard for wthru_dcache. The driver pushes expected load data
// into a queue; a monitor pops and compares when the load completes.
module wthru_dcache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall, mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int          n_run = 0, n_fail = 0;
    logic [31:0] mem_arr [256];
    logic [31:0] ref_arr [256];
    logic [31:0] exp_q [$];
    logic [31:0] rd_log [$];
    int          wr_cnt = 0;
    int          both_cnt = 0;
    logic [31:0] last_wa, last_wd;
    event        rd_evt;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    wthru_dcache dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Main memory model: combinational read, write on the clock edge
    assign mem_rdata = mem_arr[mem_addr[9:2]];
    always @(posedge clk) begin
        if (mem_rd && mem_wr) both_cnt <= both_cnt + 1;
        if (mem_rd) rd_log.push_back(mem_addr);
        if (mem_wr) begin
            mem_arr[mem_addr[9:2]] <= mem_wdata;
            wr_cnt  <= wr_cnt + 1;
            last_wa <= mem_addr;
            last_wd <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Monitor: compares each completed load against the scoreboard
    initial begin
        forever begin
            @(rd_evt);
            if (exp_q.size() == 0)
                chk(1'b0, "R6 scoreboard empty", cpu_rdata, 32'h0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(cpu_rdata === e, "R3/R6 load data", cpu_rdata, e);
            end
        end
    end

    // Driver: one access, called at a falling edge
    task automatic access(input bit is_wr, input logic [31:0] a, input logic [31:0] d,
                          input bit exp_miss, input string req);
        int st;
        int wc0;
        st  = 0;
        wc0 = wr_cnt;
        rd_log.delete();
        if (!is_wr) exp_q.push_back(ref_arr[a[9:2]]);
        cpu_addr = a; cpu_wdata = d; cpu_rd = !is_wr; cpu_wr = is_wr;
        @(negedge clk);
        while (cpu_stall && st < 20) begin
            st++;
            @(negedge clk);
        end
        chk(st == (exp_miss ? 5 : 0), {req, " R4/R3 stall cycles"}, 32'(st), exp_miss ? 32'd5 : 32'd0);
        if (!is_wr) -> rd_evt;
        if (is_wr) begin
            ref_arr[a[9:2]] = d;
            chk(wr_cnt == wc0 + 1, {req, " R7 one memory write"}, 32'(wr_cnt - wc0), 32'd1);
            chk(last_wa === {a[31:2], 2'b00}, {req, " R7/R2 write address"}, last_wa, {a[31:2], 2'b00});
            chk(last_wd === d, {req, " R7 write data"}, last_wd, d);
        end else if (exp_miss) begin
            chk(rd_log.size() == 4, {req, " R5 refill count"}, 32'(rd_log.size()), 32'd4);
            for (int k = 0; k < 4 && k < rd_log.size(); k++)
                chk(rd_log[k] === {a[31:4], 2'(k), 2'b00}, {req, " R5 refill order"},
                    rd_log[k], {a[31:4], 2'(k), 2'b00});
        end
        wc0 = wr_cnt;
        @(negedge clk);
        chk(!cpu_stall, {req, " R11 no re-issue stall"}, 32'(cpu_stall), 32'd0);
        chk(wr_cnt == wc0, {req, " R11 no extra write"}, 32'(wr_cnt - wc0), 32'd0);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 32'h0, 32'h1);
            summary();
        end
    end

    // Stimulus
    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = 32'h1000_0000 + 32'(i) * 32'h0000_0101;
            ref_arr[i] = mem_arr[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(!cpu_stall && !mem_rd && !mem_wr, "R1 reset outputs low",
            {29'b0, cpu_stall, mem_rd, mem_wr}, 32'h0);

        access(1'b0, 32'h0000_0000, '0, 1'b1, "R1 R4 R6 first load misses");
        access(1'b0, 32'h0000_0008, '0, 1'b0, "R3 R5 same line hit");
        access(1'b0, 32'h0000_000E, '0, 1'b0, "R2 byte bits ignored");
        access(1'b0, 32'h0000_0014, '0, 1'b1, "R2 line1 miss");
        access(1'b0, 32'h0000_0024, '0, 1'b1, "R2 line2 miss");
        access(1'b0, 32'h0000_003C, '0, 1'b1, "R2 line3 miss");
        access(1'b0, 32'h0000_0030, '0, 1'b0, "R5 line3 word0 hit");
        access(1'b1, 32'h0000_0004, 32'hCAFE_0004, 1'b1, "R7 R8 store hit");
        access(1'b0, 32'h0000_0004, '0, 1'b0, "R8 load after store hit");
        access(1'b1, 32'h0000_0040, 32'hBEEF_0040, 1'b1, "R9 store miss");
        access(1'b0, 32'h0000_0040, '0, 1'b1, "R9 no allocate then load miss");
        access(1'b0, 32'h0000_0000, '0, 1'b1, "R10 conflict eviction");
        access(1'b0, 32'h0000_0004, '0, 1'b0, "R8 R10 written-through word reloaded");
        access(1'b1, 32'h0000_005B, 32'h1234_5678, 1'b1, "R2 R7 unaligned store miss");
        access(1'b0, 32'h0000_0014, '0, 1'b0, "R9 other line kept");
        access(1'b0, 32'h0000_0058, '0, 1'b1, "R9 R7 stored word reaches memory");

        chk(both_cnt == 0, "R12 strobes exclusive", 32'(both_cnt), 32'd0);
        chk(mem_arr[8'h16] === 32'h1234_5678, "R7 memory content", mem_arr[8'h16], 32'h1234_5678);
        chk(exp_q.size() == 0, "R6 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        summary();
    end
endmodule